// File: doc/BRIEF.md
# Nine-Line Multiplexed GPIO Controller with Change Interrupts

This block manages nine general-purpose pins. Each pin is shared with a signal of some other peripheral, such as a serial port or an auxiliary output. For each pin, software chooses one of two functions. It can be a plain I/O line. Or the pad can be handed to the alternate peripheral, which then drives the output value and the output enable. In I/O mode, software sets the direction, writes output data, and reads the pin level back.

Inputs pass through a two-stage synchronizer. An input can be armed to record a change. Any enabled I/O input that changes level, rising or falling, sets its own flag bit. One shared interrupt line is high while any flag is set. Reading a flag register returns its contents and clears that register in the same access. Pins 0 to 7 live in 8-bit registers. Pin 8 has its own narrow registers, and its function select sits in bit 1 of its data register.

Register access is a simple synchronous port. A write takes effect on the clock edge where `wr_en` is high. A read loads `rdata` on the clock edge where `rd_en` is high. `rdata` then holds that value until the next read.

Top module: `gpio_mux_irq`

## Requirements
- R1: After reset:
  - the select bits of pins 0-7 read 0xFF;
  - the data register of pin 8 reads with bit 1 set;
  - all direction, interrupt-enable and flag bits read 0;
  - `irq` is 0.
- R2: Pad multiplexing depends on each pin's select bit:
  - Select bit set: `pad_out` takes the written data bit and `pad_oe` takes the direction bit.
  - Select bit clear: `pad_out` and `pad_oe` follow `alt_out` and `alt_oe`.
  - `alt_in` carries the raw pad level only for pins whose select bit is clear, and is 0 otherwise.
- R3: Pin 8 is controlled through data register address 6:
  - bit 1 is its select (1 = I/O, 0 = alternate);
  - bit 0 is its data.
- R4: A read of a data register returns a value per pin:
  - for a pin whose direction bit is 1 (output), the written data bit;
  - for a pin whose direction bit is 0 (input), the pad level.
  - A pad change is visible to a read issued three or more cycles after it.
- R5: A rising or a falling pad transition sets that pin's flag. This requires the pin to be selected as I/O, configured as an input, and interrupt-enabled.
- R6: A transition sets no flag on a pin that fails any of these conditions:
  - it is in alternate mode;
  - it is an output;
  - its interrupt enable is clear.
- R7: `irq` is the OR of all nine flags. It stays high until the set flags are cleared by reads.
- R8: Reading flag address 4 (pins 0-7) or address 8 (pin 8) returns and clears only that register. The other flag register is unchanged.
- R9: A transition whose flag would be set in the same cycle as a read of its flag register stays recorded. That read returns the flag bit as 0, and the next read returns it as 1.
- R10: Register map, addresses 0 to 8:
  - 0: select for pins 0-7;
  - 1: direction for pins 0-7;
  - 2: data for pins 0-7;
  - 3: interrupt enable for pins 0-7;
  - 4: flags for pins 0-7;
  - 5: direction of pin 8, in bit 0;
  - 6: data of pin 8;
  - 7: interrupt enable of pin 8, in bit 0;
  - 8: flags of pin 8, in bit 0.
  - `rdata` is updated one cycle after `rd_en` and holds between reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| pad_in | input | 9 | Pad input levels |
| pad_out | output | 9 | Pad output values |
| pad_oe | output | 9 | Pad output enables |
| alt_out | input | 9 | Output values from the alternate functions |
| alt_oe | input | 9 | Output enables from the alternate functions |
| alt_in | output | 9 | Pad levels passed to the alternate functions |
| irq | output | 1 | Shared change interrupt, level |

## Verification
Assertions check four properties on every cycle:
- no flag rises without a qualified change;
- a qualified change always lands in the flag register, even against a clearing read;
- a read clears the bits it covers;
- `irq` does not drop without a flag read, and `rdata` holds between reads.

Only the bench scenarios can show the rest:
- the pad multiplexing under random select, direction and alternate values;
- the exact register address map and the pin 8 select bit placement;
- the data returned for mixed input and output pins;
- the timing of the read that collides with an edge.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
    localparam int LO_W  = 8;          // width of the low bank
    localparam int NPIN  = LO_W + 1;   // low bank plus the ninth pin
    localparam int AW    = 4;          // register address width
    localparam int DW    = LO_W;       // register data width

    typedef enum logic [AW-1:0] {
        A_SEL_LO = 4'd0,
        A_DIR_LO = 4'd1,
        A_DAT_LO = 4'd2,
        A_IEN_LO = 4'd3,
        A_FLG_LO = 4'd4,
        A_DIR_HI = 4'd5,
        A_DAT_HI = 4'd6,
        A_IEN_HI = 4'd7,
        A_FLG_HI = 4'd8
    } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] lvl,
    output logic [W-1:0] chg
);
    logic [W-1:0] stg1, stg2, prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg1 <= '0;
            stg2 <= '0;
            prev <= '0;
        end else begin
            stg1 <= d;
            stg2 <= stg1;
            prev <= stg2;
        end
    end

    assign lvl = stg2;
    assign chg = stg2 ^ prev;
endmodule

// File: rtl/gpio_flags.sv
module gpio_flags #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_v,
    input  logic [W-1:0] clr_v,
    output logic [W-1:0] flags
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_v) | set_v;
    end

    // R6: a flag bit only rises after a qualified change
    a_r6_no_unqualified_set: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & ~$past(flags) & ~$past(set_v)) == '0));

    // R9: a qualified change is kept even when its bank is being cleared
    a_r9_set_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (set_v != '0) |=> ((flags & $past(set_v)) == $past(set_v)));

    // R8: bits covered by a clearing read end up zero unless set again
    a_r8_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_v != '0) |=> ((flags & $past(clr_v) & ~$past(set_v)) == '0));
endmodule

// File: rtl/gpio_mux_irq.sv
module gpio_mux_irq
    import gpio_mux_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    input  logic [NPIN-1:0] pad_in,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pad_oe,
    input  logic [NPIN-1:0] alt_out,
    input  logic [NPIN-1:0] alt_oe,
    output logic [NPIN-1:0] alt_in,
    output logic            irq
);
    logic [LO_W-1:0] sel_lo, dir_lo, dout_lo, ien_lo;
    logic            sel_hi, dir_hi, dout_hi, ien_hi;
    logic [NPIN-1:0] sel_v, dir_v, dout_v, ien_v;
    logic [NPIN-1:0] lvl_v, chg_v, set_v, clr_v, flags, din_v;
    logic            clr_lo, clr_hi;
    reg_addr_e       a_e;

    assign a_e = reg_addr_e'(addr);

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_lo  <= '1;
            dir_lo  <= '0;
            dout_lo <= '0;
            ien_lo  <= '0;
            sel_hi  <= 1'b1;
            dir_hi  <= 1'b0;
            dout_hi <= 1'b0;
            ien_hi  <= 1'b0;
        end else if (wr_en) begin
            unique case (a_e)
                A_SEL_LO: sel_lo  <= wdata;
                A_DIR_LO: dir_lo  <= wdata;
                A_DAT_LO: dout_lo <= wdata;
                A_IEN_LO: ien_lo  <= wdata;
                A_DIR_HI: dir_hi  <= wdata[0];
                A_DAT_HI: begin
                    dout_hi <= wdata[0];
                    sel_hi  <= wdata[1];
                end
                A_IEN_HI: ien_hi  <= wdata[0];
                default: ;
            endcase
        end
    end

    assign sel_v  = {sel_hi, sel_lo};
    assign dir_v  = {dir_hi, dir_lo};
    assign dout_v = {dout_hi, dout_lo};
    assign ien_v  = {ien_hi, ien_lo};

    gpio_sync #(.W(NPIN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .lvl   (lvl_v),
        .chg   (chg_v)
    );

    assign set_v  = chg_v & sel_v & ~dir_v & ien_v;
    assign clr_lo = rd_en && (a_e == A_FLG_LO);
    assign clr_hi = rd_en && (a_e == A_FLG_HI);
    assign clr_v  = {clr_hi, {LO_W{clr_lo}}};

    gpio_flags #(.W(NPIN)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_v (set_v),
        .clr_v (clr_v),
        .flags (flags)
    );

    assign irq = |flags;

    // pad multiplexer, one slice per pin
    for (genvar i = 0; i < NPIN; i++) begin : g_pad
        assign pad_out[i] = sel_v[i] ? dout_v[i] : alt_out[i];
        assign pad_oe[i]  = sel_v[i] ? dir_v[i]  : alt_oe[i];
        assign alt_in[i]  = sel_v[i] ? 1'b0      : pad_in[i];
        assign din_v[i]   = dir_v[i] ? dout_v[i] : lvl_v[i];
    end

    // registered read port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            unique case (a_e)
                A_SEL_LO: rdata <= sel_lo;
                A_DIR_LO: rdata <= dir_lo;
                A_DAT_LO: rdata <= din_v[LO_W-1:0];
                A_IEN_LO: rdata <= ien_lo;
                A_FLG_LO: rdata <= flags[LO_W-1:0];
                A_DIR_HI: rdata <= {{(DW-1){1'b0}}, dir_hi};
                A_DAT_HI: rdata <= {{(DW-2){1'b0}}, sel_hi, din_v[LO_W]};
                A_IEN_HI: rdata <= {{(DW-1){1'b0}}, ien_hi};
                A_FLG_HI: rdata <= {{(DW-1){1'b0}}, flags[LO_W]};
                default:  rdata <= '0;
            endcase
        end
    end

    // R7: the interrupt only falls after a flag read
    a_r7_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq) && !$past(clr_lo || clr_hi)) |-> irq);

    // R10: read data holds between reads
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

// File: tb/gpio_mux_irq_test.sv
`timescale 1ns/1ps
module gpio_mux_irq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [8:0] pad_in = '0, pad_out, pad_oe, alt_out = '0, alt_oe = '0, alt_in;
    logic       irq;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    gpio_mux_irq uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .alt_out(alt_out), .alt_oe(alt_oe), .alt_in(alt_in),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; v = rdata;
    endtask

    function automatic logic [8:0] exp_flags(input logic [8:0] o, input logic [8:0] n,
        input logic [8:0] s, input logic [8:0] d, input logic [8:0] e);
        return (o ^ n) & s & ~d & e;
    endfunction

    function automatic logic [8:0] exp_mux(input logic [8:0] s, input logic [8:0] own,
        input logic [8:0] alt);
        return (s & own) | (~s & alt);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [8:0] sel, dir, ien, dout, oldp, newp, ef, din;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", irq, 0);
        chk("R1 pad_oe", pad_oe, 9'h000);
        rd(4'd0, v); chk("R1 sel_lo", v, 8'hFF);
        rd(4'd1, v); chk("R1 dir_lo", v, 8'h00);
        rd(4'd3, v); chk("R1 ien_lo", v, 8'h00);
        rd(4'd4, v); chk("R1 flg_lo", v, 8'h00);
        rd(4'd6, v); chk("R1 R3 dat_hi", v, 8'h02);
        rd(4'd7, v); chk("R1 ien_hi", v, 8'h00);

        // R2 serial-port style select, low bank 0xD8
        alt_out = 9'h1A5; alt_oe = 9'h0F3;
        wr(4'd0, 8'hD8);
        @(negedge clk);
        chk("R2 pad_oe alt", pad_oe, exp_mux(9'h1D8, 9'h000, 9'h0F3));
        chk("R2 pad_out alt", pad_out, exp_mux(9'h1D8, 9'h000, 9'h1A5));
        rd(4'd0, v); chk("R10 sel_lo", v, 8'hD8);

        // R3 pin 8 select through bit 1 of its data register
        wr(4'd6, 8'h01);
        @(negedge clk);
        chk("R3 pin8 alt", {pad_out[8], pad_oe[8]}, {alt_out[8], alt_oe[8]});
        wr(4'd6, 8'h03); wr(4'd5, 8'h01);
        @(negedge clk);
        chk("R3 pin8 gpio", {pad_out[8], pad_oe[8]}, 2'b11);
        rd(4'd5, v); chk("R10 dir_hi", v, 8'h01);

        // R9 edge coinciding with flag read, R8 bank isolation
        wr(4'd0, 8'hFF); wr(4'd1, 8'h00); wr(4'd5, 8'h00); wr(4'd6, 8'h02);
        wr(4'd3, 8'h03); wr(4'd7, 8'h01);
        @(negedge clk); pad_in = 9'h102;
        repeat (4) @(negedge clk);
        chk("R5 R7 irq set", irq, 1);
        pad_in = 9'h103;
        @(negedge clk);
        rd(4'd4, v); chk("R9 read at edge", v, 8'h02);
        rd(4'd4, v); chk("R9 edge kept", v, 8'h01);
        chk("R7 irq held by hi", irq, 1);
        rd(4'd8, v); chk("R8 hi flag kept", v, 8'h01);
        @(negedge clk);
        chk("R7 irq cleared", irq, 0);

        // R6 masked pin: output pin 1 does not flag
        wr(4'd1, 8'h02);
        @(negedge clk); pad_in = 9'h101;
        repeat (4) @(negedge clk);
        rd(4'd4, v); chk("R6 output pin no flag", v, 8'h00);
        chk("R6 irq low", irq, 0);

        // random configurations
        oldp = pad_in;
        for (int it = 0; it < 40; it++) begin
            sel = 9'($urandom); dir = 9'($urandom); ien = 9'($urandom);
            dout = 9'($urandom);
            alt_out = 9'($urandom); alt_oe = 9'($urandom);
            wr(4'd0, sel[7:0]); wr(4'd1, dir[7:0]); wr(4'd2, dout[7:0]);
            wr(4'd3, ien[7:0]); wr(4'd5, {7'd0, dir[8]});
            wr(4'd6, {6'd0, sel[8], dout[8]}); wr(4'd7, {7'd0, ien[8]});
            repeat (3) @(negedge clk);
            rd(4'd4, v); rd(4'd8, v);
            newp = 9'($urandom);
            @(negedge clk); pad_in = newp;
            repeat (4) @(negedge clk);
            ef = exp_flags(oldp, newp, sel, dir, ien);
            chk("R7 irq random", irq, (ef != 9'h000));
            chk("R2 pad_out random", pad_out, exp_mux(sel, dout, alt_out));
            chk("R2 pad_oe random", pad_oe, exp_mux(sel, dir, alt_oe));
            chk("R2 alt_in random", alt_in, newp & ~sel);
            rd(4'd4, v); chk("R5 R6 flg_lo random", v, ef[7:0]);
            rd(4'd8, v); chk("R5 R6 flg_hi random", v, {7'd0, ef[8]});
            din = (dir & dout) | (~dir & newp);
            rd(4'd2, v); chk("R4 dat_lo random", v, din[7:0]);
            rd(4'd6, v); chk("R3 R4 dat_hi random", v, {6'd0, sel[8], din[8]});
            chk("R8 irq after reads", irq, 0);
            oldp = newp;
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule